// File: doc/BRIEF.md
# Host Message Queue Slot

This block is one message slot that carries whole messages from a producer (host) bus to a consumer (CPU) bus. Each side reaches it through a register window. The window holds a command register, a status register, a header area and a payload area. The slot keeps several fixed-size message entries in a ring, with a write pointer, a read pointer and a count of committed entries.

The producer claims a free entry and writes its header and payload words. It then commits the entry with a ready command. Data written after the claim stays hidden from the consumer until that commit. The consumer reads the header and payload of the oldest committed entry, then discards it to move on to the next one. Either side can purge the slot, which empties it at once.

The first header word carries the payload length in words, so the consumer knows how many data words to read. The block stores that word unchanged and does not interpret it. The `full` and `empty` flags feed status and interrupt logic outside the block.

Top module: `msg_queue_slot`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, and the status register reads 0 on both windows.
- R2: A command word at window offset 0 with bit 24 set claims an entry, and one with bit 26 set commits it. Header word i is at offset 0x1000+4i and data word i is at offset 0x2000+4i. After the commit, the consumer reads back exactly the words the producer wrote.
- R3: A committed message becomes visible (`empty` falls, status bit 1 rises) on the clock edge that captures the ready command. It is not visible before that edge.
- R4: The consumer always reads the oldest committed entry. A consumer command with bit 27 set (discard) moves the read side to the next entry.
- R5: `full` and status bit 0 are 1 exactly when the committed entries plus a claimed entry equal ENTRIES.
- R6: A claim issued while the slot is full is ignored. A later ready therefore commits nothing and leaves the pointers unchanged.
- R7: Header and data writes made while no claim is outstanding leave the stored words unchanged.
- R8: A ready without an outstanding claim has no effect, and neither has a discard on an empty slot.
- R9: A command with bit 25 set (purge), from either window, empties the slot. It drops the committed entries and any claimed, partly written entry.
- R10: Purge wins over every other command bit written in the same cycle.
- R11: The status register at offset 4 reads bit 0 = full and bit 1 = a message is available, with all other bits 0. It reads the same on both windows.
- R12: The producer window ignores discard. The consumer window ignores claim, ready and all header or data writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_we | input | 1 | Producer window write strobe |
| prod_addr | input | 14 | Producer window byte address |
| prod_wdata | input | 32 | Producer write data |
| prod_rdata | output | 32 | Producer read data (status, else 0) |
| cons_we | input | 1 | Consumer window write strobe |
| cons_addr | input | 14 | Consumer window byte address |
| cons_wdata | input | 32 | Consumer write data |
| cons_rdata | output | 32 | Consumer read data (status, header or data of oldest entry) |
| full | output | 1 | All entries committed or claimed |
| empty | output | 1 | No committed entry |

## Verification
The bench builds the slot with ENTRIES=2, HDR_WORDS=2 and DATA_WORDS=8. With two entries, the slot becomes full after one commit and one claim, so claims issued while full are easy to reach. The ring pointers also wrap after a few messages. That wrap is what lets the bench show that a write without a claim leaves a stale word in a reused entry untouched. The small payload area keeps all addresses inside a few words, so the ordering, purge-priority and side-restriction cases each take only a handful of cycles.

// File: rtl/mqs_pkg.sv
package mqs_pkg;
    localparam int ADDR_W          = 14;
    localparam int BUS_W           = 32;
    localparam int IDX_W           = 10;
    // command bit positions inside the command word
    localparam int CMD_CLAIM_BIT   = 24;
    localparam int CMD_PURGE_BIT   = 25;
    localparam int CMD_READY_BIT   = 26;
    localparam int CMD_DISCARD_BIT = 27;

    typedef enum logic [1:0] {
        RGN_REG  = 2'd0,
        RGN_HDR  = 2'd1,
        RGN_DATA = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    typedef struct packed {
        logic claim;
        logic ready;
        logic discard;
        logic purge;
    } slot_cmd_t;
endpackage

// File: rtl/mqs_decode.sv
module mqs_decode
    import mqs_pkg::*;
#(
    parameter int HDR_WORDS  = 2,
    parameter int DATA_WORDS = 128,
    parameter bit CONSUMER   = 1'b0
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output slot_cmd_t         cmd,
    output logic              hdr_we,
    output logic              data_we,
    output logic              stat_sel,
    output logic              hdr_sel,
    output logic              data_sel,
    output logic [IDX_W-1:0]  idx
);
    localparam bit PROD = !CONSUMER;

    region_e rgn;
    logic    cmd_wr;
    logic    unused_bits;

    always_comb begin
        rgn      = region_e'(addr[13:12]);
        idx      = addr[11:2];
        stat_sel = (rgn == RGN_REG) && (idx == IDX_W'(1));
        hdr_sel  = (rgn == RGN_HDR) && (idx < IDX_W'(HDR_WORDS));
        data_sel = (rgn == RGN_DATA) && (idx < IDX_W'(DATA_WORDS));
        cmd_wr   = we && (rgn == RGN_REG) && (idx == '0);
        cmd.purge   = cmd_wr && wdata[CMD_PURGE_BIT];
        cmd.claim   = PROD && cmd_wr && wdata[CMD_CLAIM_BIT];
        cmd.ready   = PROD && cmd_wr && wdata[CMD_READY_BIT];
        cmd.discard = CONSUMER && cmd_wr && wdata[CMD_DISCARD_BIT];
    end

    generate
        if (CONSUMER) begin : g_cons
            assign hdr_we  = 1'b0;
            assign data_we = 1'b0;
        end else begin : g_prod
            assign hdr_we  = we && hdr_sel;
            assign data_we = we && data_sel;
        end
    endgenerate

    assign unused_bits = ^{addr[1:0], wdata};
endmodule

// File: rtl/mqs_ctrl.sv
module mqs_ctrl
    import mqs_pkg::*;
#(
    parameter  int ENTRIES = 4,
    localparam int PTR_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CNT_W   = $clog2(ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  slot_cmd_t        p_cmd,
    input  slot_cmd_t        c_cmd,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic             claimed,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [PTR_W-1:0] rd_ptr;
        logic [PTR_W-1:0] wr_ptr;
        logic [CNT_W-1:0] count;
        logic             claimed;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  purge, full_now, do_claim, do_ready, do_disc;
    logic  unused_cmd;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        purge    = p_cmd.purge || c_cmd.purge;
        full_now = (st_q.count + CNT_W'(st_q.claimed)) == CNT_W'(ENTRIES);
        do_claim = p_cmd.claim && !st_q.claimed && !full_now;
        do_ready = p_cmd.ready && st_q.claimed;
        do_disc  = c_cmd.discard && (st_q.count != '0);
        if (purge) begin
            st_d = '0;
        end else begin
            if (do_claim) st_d.claimed = 1'b1;
            if (do_ready) begin
                st_d.claimed = 1'b0;
                st_d.wr_ptr  = step(st_q.wr_ptr);
            end
            if (do_disc) st_d.rd_ptr = step(st_q.rd_ptr);
            st_d.count = st_q.count + CNT_W'(do_ready) - CNT_W'(do_disc);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_ptr     = st_q.rd_ptr;
    assign wr_ptr     = st_q.wr_ptr;
    assign claimed    = st_q.claimed;
    assign full       = full_now;
    assign empty      = (st_q.count == '0);
    assign unused_cmd = ^{p_cmd.discard, c_cmd.claim, c_cmd.ready};

    a_r9_purge_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (p_cmd.purge || c_cmd.purge) |=> (empty && !claimed && !full));

    a_r10_purge_beats_claim: assert property (@(posedge clk) disable iff (!rst_n)
        (p_cmd.purge && p_cmd.claim) |=> !claimed);

    a_r6_claim_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && p_cmd.claim && !p_cmd.ready && !purge) |=>
        ($stable(wr_ptr) && (claimed == $past(claimed))));

    a_r8_ready_without_claim: assert property (@(posedge clk) disable iff (!rst_n)
        (!claimed && p_cmd.ready && !purge && !c_cmd.discard) |=>
        ($stable(wr_ptr) && $stable(empty)));

    a_r8_discard_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && c_cmd.discard && !purge) |=> $stable(rd_ptr));

    a_r3_commit_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (claimed && p_cmd.ready && !purge && !c_cmd.discard) |=> !empty);
endmodule

// File: rtl/mqs_store.sv
module mqs_store
    import mqs_pkg::*;
#(
    parameter  int ENTRIES    = 4,
    parameter  int HDR_WORDS  = 2,
    parameter  int DATA_WORDS = 128,
    localparam int PTR_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int WPE        = HDR_WORDS + DATA_WORDS,
    localparam int DEPTH      = ENTRIES * WPE,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_hdr,
    input  logic             we_data,
    input  logic [PTR_W-1:0] wr_entry,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [BUS_W-1:0] wdata,
    input  logic [PTR_W-1:0] rd_entry,
    input  logic             rd_is_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [BUS_W-1:0] rdata
);
    logic [BUS_W-1:0] mem_q [DEPTH];
    logic [AW-1:0]    waddr, raddr;

    function automatic logic [AW-1:0] locate(input logic [PTR_W-1:0] e,
                                             input logic is_data,
                                             input logic [IDX_W-1:0] i);
        return AW'(int'(e) * WPE + (is_data ? HDR_WORDS : 0) + int'(i));
    endfunction

    always_comb begin
        waddr = locate(wr_entry, we_data, wr_idx);
        raddr = locate(rd_entry, rd_is_data, rd_idx);
        rdata = ({1'b0, raddr} < (AW + 1)'(DEPTH)) ? mem_q[raddr] : '0;
    end

    always_ff @(posedge clk) begin
        if (we_hdr || we_data) mem_q[waddr] <= wdata;
    end
endmodule

// File: rtl/msg_queue_slot.sv
module msg_queue_slot
    import mqs_pkg::*;
#(
    parameter  int ENTRIES    = 4,
    parameter  int HDR_WORDS  = 2,
    parameter  int DATA_WORDS = 128,
    localparam int PTR_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prod_we,
    input  logic [ADDR_W-1:0] prod_addr,
    input  logic [BUS_W-1:0]  prod_wdata,
    output logic [BUS_W-1:0]  prod_rdata,
    input  logic              cons_we,
    input  logic [ADDR_W-1:0] cons_addr,
    input  logic [BUS_W-1:0]  cons_wdata,
    output logic [BUS_W-1:0]  cons_rdata,
    output logic              full,
    output logic              empty
);
    slot_cmd_t        p_cmd, c_cmd;
    logic             p_hdr_we, p_data_we, p_stat, p_hsel, p_dsel;
    logic             c_hdr_we, c_data_we, c_stat, c_hsel, c_dsel;
    logic [IDX_W-1:0] p_idx, c_idx;
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic             claimed;
    logic [BUS_W-1:0] store_rdata, status;
    logic             unused_sel;

    mqs_decode #(.HDR_WORDS(HDR_WORDS), .DATA_WORDS(DATA_WORDS), .CONSUMER(1'b0)) u_pdec (
        .we(prod_we), .addr(prod_addr), .wdata(prod_wdata), .cmd(p_cmd),
        .hdr_we(p_hdr_we), .data_we(p_data_we), .stat_sel(p_stat),
        .hdr_sel(p_hsel), .data_sel(p_dsel), .idx(p_idx));

    mqs_decode #(.HDR_WORDS(HDR_WORDS), .DATA_WORDS(DATA_WORDS), .CONSUMER(1'b1)) u_cdec (
        .we(cons_we), .addr(cons_addr), .wdata(cons_wdata), .cmd(c_cmd),
        .hdr_we(c_hdr_we), .data_we(c_data_we), .stat_sel(c_stat),
        .hdr_sel(c_hsel), .data_sel(c_dsel), .idx(c_idx));

    mqs_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .p_cmd(p_cmd), .c_cmd(c_cmd),
        .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .claimed(claimed),
        .full(full), .empty(empty));

    // writes land only in the entry currently claimed by the producer
    mqs_store #(.ENTRIES(ENTRIES), .HDR_WORDS(HDR_WORDS), .DATA_WORDS(DATA_WORDS)) u_store (
        .clk(clk), .we_hdr(p_hdr_we && claimed), .we_data(p_data_we && claimed),
        .wr_entry(wr_ptr), .wr_idx(p_idx), .wdata(prod_wdata),
        .rd_entry(rd_ptr), .rd_is_data(c_dsel), .rd_idx(c_idx), .rdata(store_rdata));

    always_comb begin
        status     = {{(BUS_W - 2){1'b0}}, !empty, full};
        prod_rdata = p_stat ? status : '0;
        if (c_stat)                cons_rdata = status;
        else if (c_hsel || c_dsel) cons_rdata = store_rdata;
        else                       cons_rdata = '0;
    end

    assign unused_sel = ^{p_hsel, p_dsel, c_hdr_we, c_data_we};

    a_r7_no_write_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !claimed) |-> !(u_store.we_hdr || u_store.we_data));

    a_r11_status_shape: assert property (@(posedge clk) disable iff (!rst_n)
        c_stat |-> (cons_rdata[BUS_W-1:2] == '0 && cons_rdata[1] == !empty));
endmodule

// File: tb/sim_msg_queue_slot.sv
module sim_msg_queue_slot;
    localparam int ENTRIES = 2;
    localparam int HDRW    = 2;
    localparam int DATW    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prod_we = 1'b0, cons_we = 1'b0;
    logic [13:0] prod_addr = '0, cons_addr = '0;
    logic [31:0] prod_wdata = '0, cons_wdata = '0;
    logic [31:0] prod_rdata, cons_rdata;
    logic        full, empty;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    msg_queue_slot #(.ENTRIES(ENTRIES), .HDR_WORDS(HDRW), .DATA_WORDS(DATW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .prod_we(prod_we), .prod_addr(prod_addr), .prod_wdata(prod_wdata), .prod_rdata(prod_rdata),
        .cons_we(cons_we), .cons_addr(cons_addr), .cons_wdata(cons_wdata), .cons_rdata(cons_rdata),
        .full(full), .empty(empty));

    typedef struct packed {
        logic        cons;
        logic        wr;
        logic [13:0] addr;
        logic [31:0] val;
        logic [3:0]  req;
    } vec_t;

    localparam logic P = 1'b0, C = 1'b1, W = 1'b1, RD = 1'b0;
    localparam logic [13:0] A_CMD = 14'h0000, A_ST = 14'h0004, A_H0 = 14'h1000,
                            A_H1 = 14'h1004, A_D0 = 14'h2000, A_D1 = 14'h2004;
    localparam logic [31:0] K_CLM = 32'h0100_0000, K_PRG = 32'h0200_0000,
                            K_RDY = 32'h0400_0000, K_DSC = 32'h0800_0000;
    localparam int NV = 58;

    localparam vec_t [0:NV-1] VECS = '{
        '{P, RD, A_ST, 32'h0, 4'd1},   // R1 status after reset
        '{P, W,  A_CMD, K_CLM, 4'd2},
        '{P, W,  A_H0, 32'h3, 4'd2},
        '{P, W,  A_H1, 32'hA5, 4'd2},
        '{P, W,  A_D0, 32'h11, 4'd2},
        '{P, W,  A_D1, 32'h22, 4'd2},
        '{C, RD, A_ST, 32'h0, 4'd3},   // R3 hidden before ready
        '{P, W,  A_CMD, K_RDY, 4'd2},
        '{C, RD, A_ST, 32'h2, 4'd3},   // R3 visible after ready
        '{C, RD, A_H0, 32'h3, 4'd2},   // R2 header word 0
        '{C, RD, A_H1, 32'hA5, 4'd2},  // R2 header word 1
        '{C, RD, A_D1, 32'h22, 4'd2},  // R2 data word 1
        '{P, W,  A_CMD, K_CLM, 4'd5},
        '{P, W,  A_D0, 32'h33, 4'd5},
        '{P, RD, A_ST, 32'h3, 4'd11},  // R11 producer status full+avail, R5
        '{P, W,  A_CMD, K_CLM, 4'd6},  // R6 extra claim
        '{P, W,  A_CMD, K_RDY, 4'd5},
        '{C, RD, A_ST, 32'h3, 4'd5},   // R5 two committed
        '{P, W,  A_CMD, K_CLM, 4'd6},  // R6 claim while full
        '{P, W,  A_D0, 32'h77, 4'd7},  // R7 write with no claim
        '{C, RD, A_D0, 32'h11, 4'd7},  // R7 oldest untouched, R4
        '{C, W,  A_CMD, K_DSC, 4'd4},
        '{C, RD, A_D0, 32'h33, 4'd4},  // R4 second message now
        '{C, RD, A_ST, 32'h2, 4'd6},   // R6 full dropped, nothing claimed
        '{C, W,  A_CMD, K_DSC, 4'd4},
        '{C, RD, A_ST, 32'h0, 4'd4},   // R4 drained
        '{C, W,  A_CMD, K_DSC, 4'd8},  // R8 discard on empty
        '{C, RD, A_ST, 32'h0, 4'd8},
        '{P, W,  A_CMD, K_RDY, 4'd8},  // R8 ready without claim
        '{C, RD, A_ST, 32'h0, 4'd8},
        '{P, W,  A_D0, 32'h99, 4'd7},  // R7 unclaimed write to reused entry
        '{P, W,  A_CMD, K_CLM, 4'd7},
        '{P, W,  A_CMD, K_RDY, 4'd7},
        '{C, RD, A_D0, 32'h11, 4'd7},  // R7 stale word kept
        '{C, RD, A_ST, 32'h2, 4'd8},   // R8 earlier no-ops left one message
        '{C, W,  A_CMD, K_PRG, 4'd9},  // R9 consumer purge
        '{P, RD, A_ST, 32'h0, 4'd9},
        '{P, W,  A_CMD, K_CLM, 4'd9},
        '{P, W,  A_D0, 32'h44, 4'd9},
        '{P, W,  A_CMD, K_PRG, 4'd9},  // R9 purge drops partial
        '{P, RD, A_ST, 32'h0, 4'd9},
        '{P, W,  A_CMD, K_RDY, 4'd9},
        '{C, RD, A_ST, 32'h0, 4'd9},   // R9 claim gone
        '{P, W,  A_CMD, K_CLM | K_PRG, 4'd10}, // R10
        '{P, W,  A_CMD, K_RDY, 4'd10},
        '{C, RD, A_ST, 32'h0, 4'd10},
        '{P, W,  A_CMD, K_CLM, 4'd10},
        '{P, W,  A_D0, 32'h55, 4'd10},
        '{P, W,  A_CMD, K_RDY | K_PRG, 4'd10}, // R10
        '{C, RD, A_ST, 32'h0, 4'd10},
        '{C, W,  A_CMD, K_CLM, 4'd12}, // R12 consumer claim ignored
        '{C, W,  A_D0, 32'h66, 4'd12}, // R12 consumer data write ignored
        '{P, W,  A_D0, 32'h67, 4'd12}, // no claim: ignored too
        '{P, W,  A_CMD, K_CLM, 4'd12},
        '{P, W,  A_CMD, K_RDY, 4'd12},
        '{C, RD, A_D0, 32'h55, 4'd12}, // R12 word unchanged
        '{P, W,  A_CMD, K_DSC, 4'd12}, // R12 producer discard ignored
        '{C, RD, A_ST, 32'h2, 4'd12}
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        prod_we = 1'b0; cons_we = 1'b0;
        if (v.cons) begin
            cons_we = v.wr; cons_addr = v.addr; cons_wdata = v.val;
        end else begin
            prod_we = v.wr; prod_addr = v.addr; prod_wdata = v.val;
        end
        #1;
        if (!v.wr)
            check(v.cons ? cons_rdata : prod_rdata, v.val, int'(v.req), "vector read");
    endtask

    task automatic pcmd(input logic [31:0] k);
        @(negedge clk);
        cons_we = 1'b0; prod_we = 1'b1; prod_addr = A_CMD; prod_wdata = k;
    endtask

    task automatic idle();
        @(negedge clk);
        prod_we = 1'b0; cons_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({31'b0, empty}, 32'd1, 1, "empty after reset");   // R1
        check({31'b0, full},  32'd0, 1, "full after reset");    // R1
        check(cons_rdata, 32'h0, 11, "consumer addr 0 read");  // R11 command reg reads 0

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);
        idle();
        pcmd(K_PRG);
        idle();

        // R3: exact visibility edge
        pcmd(K_CLM);
        pcmd(K_RDY);
        #1 check({31'b0, empty}, 32'd1, 3, "empty before ready edge");
        @(posedge clk); #1;
        check({31'b0, empty}, 32'd0, 3, "empty after ready edge");
        // R5: full port after one commit plus one claim
        pcmd(K_CLM);
        #1 check({31'b0, full}, 32'd0, 5, "full before claim edge");
        @(posedge clk); #1;
        check({31'b0, full}, 32'd1, 5, "full after claim edge");
        // R1: reset mid-run clears state
        idle();
        rst_n = 1'b0;
        @(posedge clk); #1;
        check({30'b0, full, empty}, 32'd1, 1, "flags after mid-run reset");
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", checks - fails, checks);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule